// File: doc/BRIEF.md
# Half to Single Precision Converter

This block widens a 16-bit half-precision floating-point value into a 32-bit single-precision value. The widening is exact, so no rounding logic is needed. One registered stage sits between the inputs and the outputs. Every input pattern gets a result on the clock edge that follows.

A mode select chooses how the half value is read. In IEEE mode, the top exponent code marks infinity or NaN. In extended-range mode, the top exponent code is an ordinary finite exponent, and the format has no infinity or NaN.

NaNs in IEEE mode travel through a canonical form. The payload is kept and the result is made quiet. A signalling NaN raises the invalid flag. A second select, default-NaN mode, replaces every NaN result with one fixed pattern. Subnormal halves are normalized into ordinary single-precision numbers.

Top module: `hcvt_h2s`

## Requirements
- R1: Each output is registered, so the inputs sampled at one rising edge appear on `single_o` and `invalid_o` after that edge. While `rst` is high at a rising edge, both outputs clear to zero.
- R2: The half value is decoded as sign in bit 15, exponent in bits 14:10 and fraction in bits 9:0. The single result has sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0. When the half exponent is 1..30, the result keeps the sign, takes exponent = half exponent + 112, and takes fraction = half fraction shifted left by 13.
- R3: In IEEE mode (`ieee_i`=1) with default-NaN mode off, an input with exponent 31 and a nonzero fraction gives a NaN. The result keeps the sign, has exponent 0xFF, and has fraction = (half fraction with bit 9 forced to 1) shifted left by 13.
- R4: In IEEE mode with `dn_i`=1, every NaN input gives 0x7FC00000, whatever its sign and payload.
- R5: `invalid_o` is 1 only for a signalling NaN in IEEE mode. A signalling NaN has exponent 31, a nonzero fraction and fraction bit 9 = 0. The flag is raised whether `dn_i` is 0 or 1, and it is 0 for every other input and mode.
- R6: In IEEE mode, exponent 31 with a zero fraction gives a signed infinity: the sign is kept, the exponent is 0xFF and the fraction is 0.
- R7: A zero input, with exponent 0 and fraction 0, gives a zero of the same sign (0x00000000 or 0x80000000) in either mode.
- R8: A subnormal input, with exponent 0 and fraction f nonzero, gives the same value f·2^-24 as a normal single. If the leading one of f is at bit p, the exponent is 103+p and the fraction holds the bits of f below p, left-aligned.
- R9: In extended-range mode (`ieee_i`=0), exponent 31 is finite. It gives exponent 143 and fraction = half fraction << 13, `dn_i` has no effect, and `invalid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_i | input | 16 | Half-precision operand |
| ieee_i | input | 1 | 1 = IEEE interpretation, 0 = extended-range interpretation |
| dn_i | input | 1 | 1 = replace NaN results with the default NaN |
| single_o | output | 32 | Single-precision result, registered |
| invalid_o | output | 1 | Invalid-operation flag for a signalling NaN, registered |

## Verification
The block holds no state beyond its output register. A fault in the classification, the leading-zero count or the exponent arithmetic therefore shows at the ports on the very next edge, as a wrong single word or a wrong flag for that one operand.

The subnormal and NaN paths are the likeliest places for a fault to hide. Sweeping every half code in IEEE mode, with default-NaN mode toggling across the sweep, exposes an off-by-one in the normalization shift or a lost quiet bit within one cycle of the bad operand. Random operands in extended-range mode then cover the top exponent as a finite number.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  localparam int H_EXP_W    = 5;
  localparam int H_FRAC_W   = 10;
  localparam int S_EXP_W    = 8;
  localparam int S_FRAC_W   = 23;
  localparam int H_W        = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_W        = 1 + S_EXP_W + S_FRAC_W;
  localparam int H_BIAS     = (1 << (H_EXP_W - 1)) - 1;
  localparam int S_BIAS     = (1 << (S_EXP_W - 1)) - 1;
  localparam int BIAS_DELTA = S_BIAS - H_BIAS;
  localparam int FRAC_SHIFT = S_FRAC_W - H_FRAC_W;
  localparam int LZC_W      = $clog2(H_FRAC_W + 1);

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } hcls_e;

  typedef struct packed {
    logic                sign;
    logic [H_EXP_W-1:0]  exp;
    logic [H_FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic                sign;
    logic [S_EXP_W-1:0]  exp;
    logic [S_FRAC_W-1:0] frac;
  } single_t;
endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
  import hcvt_pkg::*;
(
  input  half_t h,
  input  logic  ieee,
  output hcls_e cls
);
  localparam logic [H_EXP_W-1:0] EXP_TOP = '1;

  logic frac_nz;
  assign frac_nz = |h.frac;

  always_comb begin
    if (h.exp == '0) begin
      cls = frac_nz ? CLS_SUB : CLS_ZERO;
    end else if (h.exp == EXP_TOP && ieee) begin
      if (!frac_nz)                cls = CLS_INF;
      else if (h.frac[H_FRAC_W-1]) cls = CLS_QNAN;
      else                         cls = CLS_SNAN;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic hit;

  always_comb begin
    cnt = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec[i]) hit = 1'b1;
        else        cnt = cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/hcvt_pack.sv
module hcvt_pack
  import hcvt_pkg::*;
(
  input  half_t            h,
  input  hcls_e            cls,
  input  logic             dn,
  input  logic [LZC_W-1:0] lz,
  output single_t          res,
  output logic             invalid
);
  localparam logic [S_EXP_W-1:0] SEXP_TOP = '1;

  logic [H_FRAC_W-1:0] sub_frac;
  logic [S_EXP_W-1:0]  sub_exp;
  logic [S_EXP_W-1:0]  norm_exp;
  logic [H_FRAC_W-1:0] nan_frac;

  // Shift out the leading one together with the zeros above it.
  assign sub_frac = h.frac << (lz + LZC_W'(1));
  assign sub_exp  = S_EXP_W'(BIAS_DELTA) - S_EXP_W'(lz);
  assign norm_exp = S_EXP_W'(h.exp) + S_EXP_W'(BIAS_DELTA);
  assign nan_frac = h.frac | {1'b1, {(H_FRAC_W-1){1'b0}}};

  always_comb begin
    res     = '0;
    invalid = 1'b0;
    unique case (cls)
      CLS_ZERO: res = '{sign: h.sign, exp: '0, frac: '0};
      CLS_SUB:  res = '{sign: h.sign, exp: sub_exp,
                        frac: {sub_frac, {FRAC_SHIFT{1'b0}}}};
      CLS_NORM: res = '{sign: h.sign, exp: norm_exp,
                        frac: {h.frac, {FRAC_SHIFT{1'b0}}}};
      CLS_INF:  res = '{sign: h.sign, exp: SEXP_TOP, frac: '0};
      CLS_QNAN, CLS_SNAN: begin
        invalid = (cls == CLS_SNAN);
        if (dn) res = '{sign: 1'b0, exp: SEXP_TOP,
                        frac: {1'b1, {(S_FRAC_W-1){1'b0}}}};
        else    res = '{sign: h.sign, exp: SEXP_TOP,
                        frac: {nan_frac, {FRAC_SHIFT{1'b0}}}};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/hcvt_h2s.sv
module hcvt_h2s
  import hcvt_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] half_i,
  input  logic           ieee_i,
  input  logic           dn_i,
  output logic [S_W-1:0] single_o,
  output logic           invalid_o
);
  half_t            h;
  hcls_e            cls;
  logic [LZC_W-1:0] lz;
  single_t          res_d;
  logic             inv_d;

  assign h = half_t'(half_i);

  hcvt_classify u_cls (
    .h    (h),
    .ieee (ieee_i),
    .cls  (cls)
  );

  hcvt_lzc #(.W(H_FRAC_W), .CW(LZC_W)) u_lzc (
    .vec (h.frac),
    .cnt (lz)
  );

  hcvt_pack u_pack (
    .h       (h),
    .cls     (cls),
    .dn      (dn_i),
    .lz      (lz),
    .res     (res_d),
    .invalid (inv_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      single_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      single_o  <= S_W'(res_d);
      invalid_o <= inv_d;
    end
  end
endmodule

// File: rtl/hcvt_h2s_chk.sv
module hcvt_h2s_chk
  import hcvt_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [H_W-1:0] half_i,
  input logic           ieee_i,
  input logic           dn_i,
  input logic [S_W-1:0] single_o,
  input logic           invalid_o
);
  localparam logic [H_EXP_W-1:0] HTOP = '1;

  logic [H_EXP_W-1:0]  in_exp;
  logic [H_FRAC_W-1:0] in_frac;
  logic                in_nan;
  logic                in_snan;

  assign in_exp  = half_i[H_W-2 -: H_EXP_W];
  assign in_frac = half_i[H_FRAC_W-1:0];
  assign in_nan  = ieee_i && (in_exp == HTOP) && (in_frac != '0);
  assign in_snan = in_nan && !in_frac[H_FRAC_W-1];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (single_o == '0) && !invalid_o);

  p_normal_fields_r2: assert property (@(posedge clk) disable iff (rst)
    (in_exp != '0 && in_exp != HTOP) |=>
      (single_o[S_W-2 -: S_EXP_W] == S_EXP_W'($past(in_exp)) + S_EXP_W'(BIAS_DELTA)) &&
      (single_o[S_FRAC_W-1:0] == {$past(in_frac), {FRAC_SHIFT{1'b0}}}) &&
      (single_o[S_W-1] == $past(half_i[H_W-1])));

  p_nan_is_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ((single_o[S_W-2 -: S_EXP_W] == '1) && (single_o[S_FRAC_W-1:0] != '0))
      |-> single_o[S_FRAC_W-1]);

  p_default_nan_r4: assert property (@(posedge clk) disable iff (rst)
    (in_nan && dn_i) |=> (single_o == 32'h7FC0_0000));

  p_invalid_src_r5: assert property (@(posedge clk) disable iff (rst)
    in_snan |=> invalid_o);

  p_invalid_only_r5: assert property (@(posedge clk) disable iff (rst)
    !in_snan |=> !invalid_o);

  p_alt_top_r9: assert property (@(posedge clk) disable iff (rst)
    (!ieee_i && in_exp == HTOP) |=>
      (single_o[S_W-2 -: S_EXP_W] == S_EXP_W'(BIAS_DELTA) + S_EXP_W'(HTOP)));
endmodule

bind hcvt_h2s hcvt_h2s_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .half_i    (half_i),
  .ieee_i    (ieee_i),
  .dn_i      (dn_i),
  .single_o  (single_o),
  .invalid_o (invalid_o)
);

// File: tb/hcvt_h2s_bench.sv
module hcvt_h2s_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] half_i = '0;
  logic        ieee_i = 1'b1;
  logic        dn_i = 1'b0;
  logic [31:0] single_o;
  logic        invalid_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hcvt_h2s u_hcvt_h2s (
    .clk       (clk),
    .rst       (rst),
    .half_i    (half_i),
    .ieee_i    (ieee_i),
    .dn_i      (dn_i),
    .single_o  (single_o),
    .invalid_o (invalid_o)
  );

  // Behavioural reference: value-level widening, normalized by a loop.
  function automatic logic [31:0] ref_res(logic [15:0] h, logic ieee, logic dn);
    logic        s = h[15];
    logic [4:0]  e = h[14:10];
    logic [9:0]  f = h[9:0];
    logic [10:0] m;
    int          ee;
    if (e == 5'd31 && ieee) begin
      if (f == 0) return {s, 8'hFF, 23'd0};
      if (dn)     return 32'h7FC0_0000;
      return {s, 8'hFF, f | 10'h200, 13'd0};
    end
    if (e == 0) begin
      if (f == 0) return {s, 31'd0};
      m  = {1'b0, f};
      ee = 1 - 15 + 127;
      while (!m[10]) begin
        m  = m << 1;
        ee = ee - 1;
      end
      return {s, 8'(ee), m[9:0], 13'd0};
    end
    ee = int'(e) - 15 + 127;
    return {s, 8'(ee), f, 13'd0};
  endfunction

  function automatic logic ref_inv(logic [15:0] h, logic ieee);
    return ieee && h[14:10] == 5'd31 && h[9:0] != 0 && !h[9];
  endfunction

  function automatic string tag_of(logic [15:0] h, logic ieee, logic dn);
    if (h[14:10] == 5'd31 && !ieee) return "R9";
    if (h[14:10] == 5'd31 && h[9:0] == 0) return "R6";
    if (h[14:10] == 5'd31) return dn ? "R4/R5" : "R3/R5";
    if (h[14:10] == 0 && h[9:0] == 0) return "R7";
    if (h[14:10] == 0) return "R8";
    return "R2";
  endfunction

  logic [31:0] exp_res;
  logic        exp_inv;
  string       exp_tag;
  bit          pend = 0;

  task automatic check_out();
    tests++;
    if (single_o !== exp_res || invalid_o !== exp_inv) begin
      fails++;
      $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
               exp_tag, single_o, invalid_o, exp_res, exp_inv);
    end
  endtask

  task automatic apply(logic [15:0] h, logic ieee, logic dn);
    @(negedge clk);
    if (pend) check_out();
    half_i  = h;
    ieee_i  = ieee;
    dn_i    = dn;
    exp_res = ref_res(h, ieee, dn);
    exp_inv = ref_inv(h, ieee);
    exp_tag = tag_of(h, ieee, dn);
    pend    = 1;
  endtask

  initial begin
    // R1: reset clears outputs even with a signalling NaN presented
    half_i = 16'h7C01; ieee_i = 1'b1; dn_i = 1'b0;
    repeat (3) @(negedge clk);
    exp_res = '0; exp_inv = 1'b0; exp_tag = "R1";
    check_out();
    rst = 1'b0;
    // R1: one-cycle latency, checked through the queue below
    apply(16'h3C00, 1, 0);  // 1.0 -> 0x3F800000 (R2)
    apply(16'hC000, 1, 0);  // -2.0 (R2)
    apply(16'h7BFF, 1, 0);  // max normal (R2)
    apply(16'h0400, 1, 0);  // min normal (R2)
    apply(16'h0001, 1, 0);  // smallest subnormal -> 0x33800000 (R8)
    apply(16'h83FF, 1, 0);  // largest negative subnormal (R8)
    apply(16'h0200, 1, 0);  // subnormal, leading one at bit 9 (R8)
    apply(16'h0000, 1, 0);  // +0 (R7)
    apply(16'h8000, 0, 1);  // -0 in extended mode (R7)
    apply(16'h7C00, 1, 0);  // +inf (R6)
    apply(16'hFC00, 1, 1);  // -inf, default-NaN has no effect (R6)
    apply(16'h7C01, 1, 0);  // signalling NaN, quieted, invalid (R3, R5)
    apply(16'hFE55, 1, 0);  // quiet NaN, no invalid (R3, R5)
    apply(16'hFD00, 1, 1);  // signalling NaN under default-NaN (R4, R5)
    apply(16'h7E00, 1, 1);  // quiet NaN under default-NaN (R4)
    apply(16'h7C01, 0, 0);  // extended mode: finite, no invalid (R9)
    apply(16'hFFFF, 0, 1);  // extended mode max magnitude (R9)
    apply(16'h7C00, 0, 0);  // extended mode 2^16 (R9)
    // Full sweep in IEEE mode, default-NaN toggling every 8 codes
    for (int i = 0; i < 65536; i++) apply(16'(i), 1, i[3]);
    // Random operands, either mode
    for (int i = 0; i < 4096; i++) apply(16'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    check_out();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule